// File: doc/BRIEF.md
# Clock-Control Register Bank with Write Protection and Bit Aliases

This block holds the 32-bit control words of a clock-control peripheral behind a simple synchronous bus. Every register has a fixed protection mask. A mask bit of 1 makes that bit read-only, so it keeps its reset value for as long as the block runs. A mask bit of 0 makes the bit writable.

The bank has two groups. Plain registers sit at word indices `0 .. NPLAIN-1`. Aliased registers start at `ALIAS_BASE`, which must be a multiple of four, and each one takes four consecutive words. The first word is the register itself. The next three words set, clear and toggle bits of that same register. All three operations are filtered by the register's mask.

A read is requested with `req_rd` and answered one cycle later on `rsp_rdata`, with `rsp_valid` high. The clock logic that these registers drive is not part of the block.

Top module: `clkctl_regbank`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, every register holds its configured reset value and `rsp_valid` is 0.
- R2: A write to a plain register (word `i < NPLAIN`) stores `(old & mask) | (wdata & ~mask)`.
- R3: A register whose mask is all ones ignores every write. A register whose mask is zero takes the whole write word.
- R4: A write to word `base+1` of an aliased register ORs `(wdata & ~mask)` into it.
- R5: A write to word `base+2` clears exactly the bits in `(wdata & ~mask)`.
- R6: A write to word `base+3` XORs `(wdata & ~mask)` into the register.
- R7: A write to word `base+0` of an aliased register uses the same masked formula as R2.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_rd` high. `rsp_rdata` then carries the register value from before any write in the request cycle. Any of the four words of an aliased register reads back that register.
- R9: A write to a word index that maps to no register changes no register, and a read from such an index returns 0.
- R10: `rsp_rdata` is 0 whenever `rsp_valid` is 0.
- R11: Under any sequence of accesses, the protected bits of every register equal their reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | AW | Word index of the access |
| req_wr | input | 1 | Write request |
| req_rd | input | 1 | Read request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rsp_rdata | output | 32 | Read data, 0 when not valid |

## Verification
The bound checker checks several properties on every clock:
- the protected bits of every register stay at their reset values;
- registers stay unchanged in cycles without a write or with a write to an unmapped word;
- `rsp_valid` tracks the previous cycle's `req_rd`;
- reads of unmapped words return zero;
- `rsp_rdata` is zero outside a response.

The values produced by the set, clear and toggle words, and by masked plain writes, come from arithmetic on the writable bits. Only the bench's behavioural model can show these, by comparing every cycle over directed and random access sequences. The same holds for read-before-write ordering within one cycle.

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int AW         = 6,
  parameter int NPLAIN     = 4,
  parameter int NALIAS     = 3,
  parameter int ALIAS_BASE = 16,
  parameter logic [NPLAIN*32-1:0] PLAIN_MASK = {32'h8000_0001, 32'hFF00_0F0F,
                                                32'h0000_0000, 32'hFFFF_FFFF},
  parameter logic [NPLAIN*32-1:0] PLAIN_RST  = {32'h8000_0000, 32'h1200_0304,
                                                32'hFFFF_FFFF, 32'h5A5A_0003},
  parameter logic [NALIAS*32-1:0] ALIAS_MASK = {32'hFFF0_0080, 32'h4040_4040,
                                                32'hC000_0000},
  parameter logic [NALIAS*32-1:0] ALIAS_RST  = {32'h0010_0081, 32'h4011_0022,
                                                32'h4000_0010}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);

  localparam int NREG = NPLAIN + NALIAS;
  localparam int GRP0 = ALIAS_BASE / 4;

  logic [NREG*32-1:0] regs_q;
  logic [31:0]        rd_val;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    localparam logic [31:0] M = PLAIN_MASK[i*32 +: 32];
    wire         hit = req_wr && (req_addr == AW'(i));
    wire  [31:0] cur = regs_q[i*32 +: 32];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   regs_q[i*32 +: 32] <= PLAIN_RST[i*32 +: 32];
      else if (hit) regs_q[i*32 +: 32] <= (cur & M) | (req_wdata & ~M);
  end

  for (genvar k = 0; k < NALIAS; k++) begin : g_alias
    localparam int          J = NPLAIN + k;
    localparam logic [31:0] M = ALIAS_MASK[k*32 +: 32];
    wire         hit = req_wr && (req_addr[AW-1:2] == (AW-2)'(GRP0 + k));
    wire  [31:0] cur = regs_q[J*32 +: 32];
    wire  [31:0] w   = req_wdata & ~M;
    logic [31:0] nxt;

    always_comb
      case (req_addr[1:0])
        2'd0:    nxt = (cur & M) | w;
        2'd1:    nxt = cur | w;
        2'd2:    nxt = cur & ~w;
        default: nxt = cur ^ w;
      endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   regs_q[J*32 +: 32] <= ALIAS_RST[k*32 +: 32];
      else if (hit) regs_q[J*32 +: 32] <= nxt;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NPLAIN; i++)
      if (req_addr == AW'(i)) rd_val = regs_q[i*32 +: 32];
    for (int k = 0; k < NALIAS; k++)
      if (req_addr[AW-1:2] == (AW-2)'(GRP0 + k)) rd_val = regs_q[(NPLAIN+k)*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_rd;
      rsp_rdata <= req_rd ? rd_val : '0;
    end

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int AW         = 6,
  parameter int NPLAIN     = 4,
  parameter int NALIAS     = 3,
  parameter int ALIAS_BASE = 16,
  parameter logic [NPLAIN*32-1:0] PLAIN_MASK = '0,
  parameter logic [NPLAIN*32-1:0] PLAIN_RST  = '0,
  parameter logic [NALIAS*32-1:0] ALIAS_MASK = '0,
  parameter logic [NALIAS*32-1:0] ALIAS_RST  = '0
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                req_addr,
  input logic                         req_wr,
  input logic                         req_rd,
  input logic                         rsp_valid,
  input logic [31:0]                  rsp_rdata,
  input logic [(NPLAIN+NALIAS)*32-1:0] regs_q
);

  logic [31:0] a32;
  logic        mapped;
  assign a32    = 32'(req_addr);
  assign mapped = (a32 < 32'(NPLAIN)) ||
                  ((a32 >= 32'(ALIAS_BASE)) && (a32 < 32'(ALIAS_BASE + 4*NALIAS)));

  for (genvar i = 0; i < NPLAIN; i++) begin : g_pp
    a_r11_plain_protected: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_q[i*32 +: 32] & PLAIN_MASK[i*32 +: 32]) ==
      (PLAIN_RST[i*32 +: 32] & PLAIN_MASK[i*32 +: 32]));
  end

  for (genvar k = 0; k < NALIAS; k++) begin : g_ap
    a_r11_alias_protected: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_q[(NPLAIN+k)*32 +: 32] & ALIAS_MASK[k*32 +: 32]) ==
      (ALIAS_RST[k*32 +: 32] & ALIAS_MASK[k*32 +: 32]));
  end

  a_r8_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);

  a_r8_no_valid_without_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid);

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !mapped) |=> (rsp_rdata == 32'h0));

  a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !mapped) |=> $stable(regs_q));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |=> $stable(regs_q));

  a_r10_rdata_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == 32'h0));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
  .AW(AW), .NPLAIN(NPLAIN), .NALIAS(NALIAS), .ALIAS_BASE(ALIAS_BASE),
  .PLAIN_MASK(PLAIN_MASK), .PLAIN_RST(PLAIN_RST),
  .ALIAS_MASK(ALIAS_MASK), .ALIAS_RST(ALIAS_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wr(req_wr),
  .req_rd(req_rd), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .regs_q(regs_q)
);

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 7;
  localparam logic [31:0] MMASK [NR] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFF00_0F0F,
                                         32'h8000_0001, 32'hC000_0000, 32'h4040_4040,
                                         32'hFFF0_0080};
  localparam logic [31:0] MRST  [NR] = '{32'h5A5A_0003, 32'hFFFF_FFFF, 32'h1200_0304,
                                         32'h8000_0000, 32'h4000_0010, 32'h4011_0022,
                                         32'h0010_0081};

  logic        clk = 0, rst_n = 0;
  logic [5:0]  req_addr = '0;
  logic        req_wr = 0, req_rd = 0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  clkctl_regbank dut_i (.clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wr(req_wr),
    .req_rd(req_rd), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0, fails = 0, cyc = 0;
  string tag = "R1 reset";

  logic [31:0] mreg [NR];
  logic        exp_valid;
  logic [31:0] exp_data, mw;
  int          mr, mop;

  function automatic int map_reg(input int a, output int op);
    op = 0;
    if (a < 4) return a;
    if (a >= 16 && a < 28) begin op = a % 4; return 4 + (a - 16) / 4; end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) mreg[i] = MRST[i];
      exp_valid = 0; exp_data = 0;
    end else begin
      mr = map_reg(int'(req_addr), mop);
      exp_valid = req_rd;
      exp_data  = (req_rd && mr >= 0) ? mreg[mr] : 32'h0;
      if (req_wr && mr >= 0) begin
        mw = req_wdata & ~MMASK[mr];
        case (mop)
          0: mreg[mr] = (mreg[mr] & MMASK[mr]) | mw;
          1: mreg[mr] = mreg[mr] | mw;
          2: mreg[mr] = mreg[mr] & ~mw;
          default: mreg[mr] = mreg[mr] ^ mw;
        endcase
      end
    end

  always @(negedge clk) begin
    vectors++;
    if (rsp_valid !== exp_valid || rsp_rdata !== exp_data) begin
      fails++;
      $display("FAIL %s: valid=%0b rdata=%h expected valid=%0b rdata=%h",
               tag, rsp_valid, rsp_rdata, exp_valid, exp_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic op(input int a, input bit wr, input bit rd, input logic [31:0] wd);
    @(negedge clk);
    req_addr = 6'(a); req_wr = wr; req_rd = rd; req_wdata = wd;
  endtask

  task automatic idle();
    op(0, 0, 0, 0);
  endtask

  task automatic sweep();
    for (int a = 0; a < 64; a++) op(a, 0, 1, 0);
    idle();
  endtask

  initial begin
    tag = "R1 reset";
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1 R9 reset readback";
    sweep();

    tag = "R2 plain masked write";
    foreach (MRST[i]) if (i == 2 || i == 3) begin
      op(i, 1, 0, 32'hFFFF_FFFF); op(i, 0, 1, 0);
      op(i, 1, 0, 32'h0000_0000); op(i, 0, 1, 0);
      op(i, 1, 0, 32'hA5A5_5A5A); op(i, 0, 1, 0);
    end
    tag = "R3 fully protected and fully writable";
    op(0, 1, 0, 32'h0); op(0, 0, 1, 0);
    op(1, 1, 0, 32'hDEAD_BEEF); op(1, 0, 1, 0);
    op(1, 1, 0, 32'h0); op(1, 0, 1, 0);

    tag = "R7 alias base write";
    for (int k = 0; k < 3; k++) begin
      op(16+4*k, 1, 0, 32'h0); op(16+4*k, 0, 1, 0);
    end
    tag = "R4 set alias";
    for (int k = 0; k < 3; k++) begin
      op(17+4*k, 1, 0, 32'hFFFF_FFFF); op(16+4*k, 0, 1, 0);
    end
    tag = "R5 clear alias";
    for (int k = 0; k < 3; k++) begin
      op(18+4*k, 1, 0, 32'h0F0F_F0F0); op(16+4*k, 0, 1, 0);
    end
    tag = "R6 toggle alias";
    for (int k = 0; k < 3; k++) begin
      op(19+4*k, 1, 0, 32'h3333_CCCC); op(16+4*k, 0, 1, 0);
      op(19+4*k, 1, 0, 32'hFFFF_FFFF); op(16+4*k, 0, 1, 0);
    end
    tag = "R8 read during write and alias reads";
    op(2, 1, 1, 32'h0055_AA00); op(2, 0, 1, 0);
    op(21, 1, 1, 32'h00FF_0000); op(22, 0, 1, 0); op(23, 0, 1, 0);
    tag = "R9 unmapped writes";
    for (int a = 4; a < 16; a++) op(a, 1, 0, 32'hFFFF_FFFF);
    for (int a = 28; a < 64; a++) op(a, 1, 1, 32'h1234_5678);
    sweep();
    tag = "R10 idle rdata";
    repeat (5) idle();

    tag = "R11 random accesses";
    for (int n = 0; n < 3000; n++)
      op(int'($urandom_range(0, 31)), 1'($urandom), 1'($urandom), $urandom);
    sweep();

    repeat (2) idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule